// File: doc/BRIEF.md
# Buffered Serializing Port with Valid Strobes

This block sits between a processor and a narrow group of pins whose data word is wider than the pins. In output mode the processor hands over one word. The port drives that word onto the pins one pin-wide chunk at a time, least significant chunk first, with one chunk per port-clock period. In input mode the port collects successive pin samples into a word, again least significant chunk first, and offers the finished word to the processor.

A single-entry holding buffer on each side decouples the processor from the shift register. The processor can therefore write, or read, without waiting for the pins. The port clock is not generated here. The block receives two single-cycle enables in the system clock domain: one marks the port clock's falling edge, on which data is driven, and one marks its rising edge, on which data is sampled. An optional valid strobe is raised while written data is on the pins. An optional qualifier input decides which rising edges take a sample. The processor side has three further controls: a sync request, a buffer clear, and a sticky overrun flag.

Top module: `ser_strobe_port`

## Requirements
- R1: On each drive-edge enable in output mode, `pins_out` takes the next pin-wide chunk of the current word, starting with bits [PIN_W-1:0] and moving upward. `pins_out` changes on no other cycle.
- R2: When `strobe_out_en` is 1, `ready_out` is 1 for exactly the XFER_W/PIN_W drive periods that carry chunks of a written word. When `strobe_out_en` is 0, `ready_out` stays 0.
- R3: When no word is left to drive, a drive edge leaves `pins_out` holding the last chunk and sets `ready_out` to 0.
- R4: `wr_ready` is 0 while the output buffer holds a word. It returns to 1 right after the drive edge on which that word's first chunk appears on the pins, so a word accepted behind a word still being driven keeps a third write waiting.
- R5: A sync request is answered by a one-cycle `sync_done` pulse. The pulse follows the first drive edge at which no chunk and no buffered word remains, which is the edge that ends the last chunk's full period.
- R6: In input mode, each sampling edge shifts `pins_in` into the word, least significant chunk first. After XFER_W/PIN_W samples the word appears on `rd_data` with `rd_valid` = 1. For example, nibbles 0x8 and then 0x2 give 0x28.
- R7: When `strobe_in_en` is 1, a sampling edge takes a sample only if `ready_in` is 1. When `strobe_in_en` is 0, `ready_in` is ignored.
- R8: A finished input word stays on `rd_data` with `rd_valid` = 1 until `rd_take` pops it or the next word completes.
- R9: If a new input word completes while an unread word is still held, the new word replaces the old one and `overrun` is set. `overrun` stays set until a clear.
- R10: `clr_buf` empties the input buffer, discards any partly assembled word and clears `overrun`.
- R11: After reset, `pins_out` = 0, `ready_out` = 0, `wr_ready` = 1, `rd_valid` = 0, `overrun` = 0 and `sync_done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_out | input | 1 | 1 = output mode, 0 = input mode |
| strobe_out_en | input | 1 | Enables generation of `ready_out` |
| strobe_in_en | input | 1 | Enables qualification of samples by `ready_in` |
| tick_fall | input | 1 | One-cycle marker of a port-clock drive edge |
| tick_rise | input | 1 | One-cycle marker of a port-clock sampling edge |
| wr_valid | input | 1 | Processor offers a word |
| wr_data | input | XFER_W | Word to serialize |
| wr_ready | output | 1 | Output buffer can accept a word |
| rd_valid | output | 1 | Input word available |
| rd_data | output | XFER_W | Assembled input word |
| rd_take | input | 1 | Processor consumes the input word |
| sync_req | input | 1 | Request to wait until output has fully drained |
| sync_done | output | 1 | One-cycle completion of a sync request |
| clr_buf | input | 1 | Discard pending input data |
| overrun | output | 1 | Sticky lost-input-word flag |
| pins_out | output | PIN_W | Driven pin values |
| ready_out | output | 1 | Valid strobe for driven data |
| pins_in | input | PIN_W | Sampled pin values |
| ready_in | input | 1 | Valid qualifier for sampled data |

## Verification
Several output words are serialized: 0x85, all zeros, all ones and 0x3C. The mixed-nibble words catch swapped chunk order. The constant words show whether stale shift bits leak into later chunks. Input words are assembled from distinct nibbles, so packing order is visible. Qualifier-low edges are placed between qualified ones, so a wrongly taken sample corrupts the result. An unread word is followed by a fresh one to separate hold from overrun. A partial word is followed by a clear to show that partial data is discarded.

// File: rtl/ser_strobe_port.sv
module ser_strobe_port #(
  parameter int PIN_W  = 4,
  parameter int XFER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_out,
  input  logic              strobe_out_en,
  input  logic              strobe_in_en,
  input  logic              tick_fall,
  input  logic              tick_rise,
  input  logic              wr_valid,
  input  logic [XFER_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [XFER_W-1:0] rd_data,
  input  logic              rd_take,
  input  logic              sync_req,
  output logic              sync_done,
  input  logic              clr_buf,
  output logic              overrun,
  output logic [PIN_W-1:0]  pins_out,
  output logic              ready_out,
  input  logic [PIN_W-1:0]  pins_in,
  input  logic              ready_in
);
  localparam int CHUNKS = XFER_W / PIN_W;
  localparam int CW     = $clog2(CHUNKS + 1);

  logic [XFER_W-1:0] obuf, oshift, ishift;
  logic              obuf_full, sync_pend;
  logic [CW-1:0]     orem, icnt;

  assign wr_ready = !obuf_full;
  wire wr_accept = wr_valid && !obuf_full;
  wire drive     = mode_out && tick_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obuf <= '0; oshift <= '0; obuf_full <= 1'b0; orem <= '0;
      pins_out <= '0; ready_out <= 1'b0; sync_pend <= 1'b0; sync_done <= 1'b0;
    end else begin
      sync_done <= 1'b0;
      if (sync_req) sync_pend <= 1'b1;
      if (wr_accept) begin
        obuf      <= wr_data;
        obuf_full <= 1'b1;
      end
      if (drive) begin
        if (orem != '0) begin
          pins_out  <= oshift[PIN_W-1:0];
          oshift    <= oshift >> PIN_W;
          orem      <= orem - 1'b1;
          ready_out <= strobe_out_en;
        end else if (obuf_full) begin
          pins_out  <= obuf[PIN_W-1:0];
          oshift    <= obuf >> PIN_W;
          orem      <= CW'(CHUNKS - 1);
          obuf_full <= 1'b0;
          ready_out <= strobe_out_en;
        end else begin
          ready_out <= 1'b0;
          if (sync_pend || sync_req) begin
            sync_done <= 1'b1;
            sync_pend <= 1'b0;
          end
        end
      end
    end
  end

  wire              sample    = !mode_out && tick_rise && (!strobe_in_en || ready_in);
  wire [XFER_W-1:0] inext     = (ishift >> PIN_W) | (XFER_W'(pins_in) << (XFER_W - PIN_W));
  wire              word_done = sample && (icnt == CW'(CHUNKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_buf) begin
      ishift <= '0; icnt <= '0; rd_data <= '0; rd_valid <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (sample) begin
        ishift <= inext;
        icnt   <= word_done ? '0 : icnt + 1'b1;
      end
      if (word_done) begin
        rd_data  <= inext;
        rd_valid <= 1'b1;
        if (rd_valid && !rd_take) overrun <= 1'b1;
      end else if (rd_take) begin
        rd_valid <= 1'b0;
      end
    end
  end

  a_r1_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |=> $stable(pins_out));
  a_r4_buffer_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);
  a_r5_sync_drained: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> (!ready_out && orem == '0));
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_take && !clr_buf) |=> rd_valid);
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_buf) |=> overrun);
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_buf |=> (!rd_valid && !overrun));
endmodule

// File: tb/tb_ser_strobe_port.sv
module tb_ser_strobe_port;
  logic clk = 0, rst_n = 0;
  logic mode_out = 1, strobe_out_en = 1, strobe_in_en = 0, tick_fall = 0, tick_rise = 0;
  logic wr_valid = 0, rd_take = 0, sync_req = 0, clr_buf = 0, ready_in = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] pins_in = 0;
  logic wr_ready, rd_valid, sync_done, overrun, ready_out;
  logic [7:0] rd_data;
  logic [3:0] pins_out;
  int total = 0, failed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ser_strobe_port #(.PIN_W(4), .XFER_W(8)) dut (
    .clk, .rst_n, .mode_out, .strobe_out_en, .strobe_in_en, .tick_fall, .tick_rise,
    .wr_valid, .wr_data, .wr_ready, .rd_valid, .rd_data, .rd_take, .sync_req,
    .sync_done, .clr_buf, .overrun, .pins_out, .ready_out, .pins_in, .ready_in);

  localparam logic [7:0] OWORDS [4] = '{8'h85, 8'h00, 8'hFF, 8'h3C};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic fall(); tick_fall = 1; cyc(); tick_fall = 0; endtask
  task automatic rise(input logic [3:0] d, input logic q);
    pins_in = d; ready_in = q; tick_rise = 1; cyc(); tick_rise = 0;
  endtask
  task automatic wr(input logic [7:0] w);
    while (!wr_ready) cyc();
    wr_valid = 1; wr_data = w; cyc(); wr_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", total, failed);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R11 reset state
    chk("R11 pins", pins_out, 0);
    chk("R11 ready_out", ready_out, 0);
    chk("R11 wr_ready", wr_ready, 1);
    chk("R11 rd_valid", rd_valid, 0);
    chk("R11 overrun", overrun, 0);
    chk("R11 sync_done", sync_done, 0);

    // R1 R2 R3 table of output words
    for (int i = 0; i < 4; i++) begin
      wr(OWORDS[i]);
      cyc();
      chk("R1 no drive without edge", pins_out, (i == 0) ? 4'h0 : OWORDS[i-1][7:4]);
      fall();
      chk("R1 chunk0", pins_out, OWORDS[i][3:0]);
      chk("R2 strobe chunk0", ready_out, 1);
      fall();
      chk("R1 chunk1", pins_out, OWORDS[i][7:4]);
      chk("R2 strobe chunk1", ready_out, 1);
      fall();
      chk("R3 idle hold", pins_out, OWORDS[i][7:4]);
      chk("R3 idle strobe low", ready_out, 0);
    end

    // R2 strobe disabled
    strobe_out_en = 0;
    wr(8'h96);
    fall();
    chk("R2 disabled strobe", ready_out, 0);
    chk("R1 chunk0 nostrobe", pins_out, 4'h6);
    fall(); fall();
    strobe_out_en = 1;

    // R4 blocking and R5 sync
    wr(8'h21);
    chk("R4 full blocks", wr_ready, 0);
    fall();
    chk("R4 freed on drive", wr_ready, 1);
    wr(8'h43);
    chk("R4 second held", wr_ready, 0);
    fall();
    chk("R4 still blocked", wr_ready, 0);
    chk("R1 first word hi", pins_out, 4'h2);
    fall();
    chk("R4 freed second", wr_ready, 1);
    chk("R1 second word lo", pins_out, 4'h3);
    sync_req = 1; cyc(); sync_req = 0;
    chk("R5 not yet", sync_done, 0);
    fall();
    chk("R5 last chunk driving", sync_done, 0);
    chk("R1 second word hi", pins_out, 4'h4);
    fall();
    chk("R5 done pulse", sync_done, 1);
    cyc();
    chk("R5 pulse one cycle", sync_done, 0);

    // input mode
    mode_out = 0;
    clr_buf = 1; cyc(); clr_buf = 0;
    rise(4'h8, 0);
    chk("R6 partial not valid", rd_valid, 0);
    rise(4'h2, 0);
    chk("R6 valid", rd_valid, 1);
    chk("R6 packing", rd_data, 8'h28);
    chk("R1 pins idle in input mode", pins_out, 4'h4);
    rise(4'hA, 1);
    chk("R8 held during next word", rd_data, 8'h28);
    chk("R8 valid held", rd_valid, 1);
    rise(4'h7, 1);
    chk("R9 overwrite", rd_data, 8'h7A);
    chk("R9 overrun set", overrun, 1);
    rd_take = 1; cyc(); rd_take = 0;
    chk("R8 take empties", rd_valid, 0);
    chk("R9 sticky", overrun, 1);

    // R7 qualifier gating
    strobe_in_en = 1;
    rise(4'h4, 1);
    rise(4'h9, 0);
    chk("R7 gated no word", rd_valid, 0);
    rise(4'h6, 1);
    chk("R7 gated word", rd_data, 8'h64);
    rd_take = 1; cyc(); rd_take = 0;
    strobe_in_en = 0;
    rise(4'h3, 0);
    rise(4'h5, 0);
    chk("R7 qualifier ignored", rd_data, 8'h53);
    chk("R7 valid", rd_valid, 1);

    // R10 clear
    rise(4'hE, 1);
    clr_buf = 1; cyc(); clr_buf = 0;
    chk("R10 buffer emptied", rd_valid, 0);
    chk("R10 overrun cleared", overrun, 0);
    rise(4'h1, 1);
    rise(4'h2, 1);
    chk("R10 partial discarded", rd_data, 8'h21);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule